// File: doc/BRIEF.md
# Converter Serial Port Responder

This block stands in for the digital side of a delta-sigma converter's serial port, so that a host-side serial controller can be exercised against a device that behaves like the real thing at its pins. After reset, a power-up interval runs before anything else happens. At the end of that interval the level on the serial clock line picks the clocking mode. A low level means the host supplies the clock. A high or undriven level (a weak pull-up, modelled as a 1) means the block generates its own clock.

The analog conversion is replaced by a timer. While the timer runs, the data output shows a busy flag (1). When the timer expires, the block loads a 22-bit result from an input port into a static shift register, and the data output drops to 0. That 0 is the first bit of the outgoing word. The host then clocks out a 24-bit frame. At the same time, the block collects the host's serial input, and the first 16 of those bits become a configuration word if they carry a valid header. The 24th falling clock edge starts the next conversion.

In self-clocked mode, the block drives a divided clock for the whole frame. The block looks at the clock line again on every falling edge of the chip select, so the host can change modes between frames.

Top module: `adc_port_responder`

## Requirements
- R1: During the POR_CYCLES cycles that follow reset, no conversion runs and `sdo` holds 1. When the interval ends, `mode_ext` is latched to 1 if `sck_pin` is low, and to 0 if `sck_pin` is high.
- R2: A conversion lasts CONV_CYCLES clock cycles. While it runs, `sdo` is 1. When it completes, `sdo` falls to 0, which is the end-of-conversion flag.
- R3: The frame is 24 bits and the first bit is 0 (end-of-conversion). The bits that follow are 0, then `result_in[21]` (sign), then `result_in[20:0]` MSB first. The value is captured when the conversion completes. Each falling edge of the serial clock advances `sdo` by one bit.
- R4: On the 24th falling serial clock edge, `sdo` goes to 1 and a new conversion starts.
- R5: `sdi` is sampled on rising serial clock edges. When the frame ends, `cfg_word` takes the first 16 sampled bits, with the first bit in bit 15, but only if bits 15 and 14 are 1 and 0.
- R6: If the header bits are anything other than 1 then 0, `cfg_word` keeps its previous value.
- R7: Serial clock edges are ignored while a conversion runs and while `cs_n` is high. They do not advance the frame.
- R8: One cycle after `cs_n` is sampled, `sdo_oe` equals its inverse.
- R9: In self-clocked mode, once a result is ready and `cs_n` is low, the block does the following:
  - It raises `sck_oe`.
  - It toggles `sck_out` every HALF_DIV cycles, so falling edges are 2*HALF_DIV cycles apart.
  - It stops after 24 falling edges.
  - `sck_oe` is never high in host-clocked mode.
- R10: A falling edge of `cs_n` while the block is not driving the clock re-latches `mode_ext` from `sck_pin`.
- R11: In reset, `mode_ext` is 0, `cfg_word` is 0, `sdo` is 1 and `sck_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_pin | input | 1 | Level of the serial clock line (pull-up reads as 1) |
| sck_out | output | 1 | Generated serial clock in self-clocked mode |
| sck_oe | output | 1 | Block drives the serial clock line |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial configuration input |
| sdo | output | 1 | Serial data / end-of-conversion flag |
| sdo_oe | output | 1 | Data output enable |
| result_in | input | RES_W | Conversion value, sign in the MSB |
| cfg_word | output | CFG_W | Last accepted configuration word |
| mode_ext | output | 1 | 1 = host-clocked mode, 0 = self-clocked mode |

## Verification
The serial clock line is sampled by one register. A host edge applied between clock edges therefore moves `sdo` at the next rising clock edge, and the bench reads it two cycles later. In self-clocked mode, the shift happens on the same edge that moves `sck_out`, so the bench checks each bit at the cycle where it sees the line rise. The power-up interval and conversion completion fall one cycle after their counters expire. The bench confirms this by counting cycles from reset release and from the 24th falling edge, with a two-cycle tolerance. `cfg_word` and `sdo_oe` are read a full cycle after the edge that updates them.

// File: rtl/port_resp_pkg.sv
package port_resp_pkg;
  typedef enum logic [1:0] {
    ST_POWERUP = 2'd0,
    ST_CONVERT = 2'd1,
    ST_SLEEP   = 2'd2
  } seq_state_t;
endpackage

// File: rtl/por_mode_ctrl.sv
module por_mode_ctrl #(
  parameter int POR_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_pin,
  input  logic cs_n,
  input  logic sck_driving,
  output logic por_done,
  output logic mode_ext
);
  localparam int CW = $clog2(POR_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      por_done <= 1'b0;
      cs_q     <= 1'b1;
      mode_ext <= 1'b0;
    end else begin
      cs_q <= cs_n;
      if (!por_done) begin
        if (cnt == CW'(POR_CYCLES - 1)) begin
          por_done <= 1'b1;
          mode_ext <= ~sck_pin;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (cs_q && !cs_n && !sck_driving) begin
        mode_ext <= ~sck_pin;
      end
    end
  end
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer import port_resp_pkg::*; #(
  parameter int CONV_CYCLES = 8192
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       por_done,
  input  logic       frame_done,
  output seq_state_t state,
  output logic       load
);
  localparam int CW = $clog2(CONV_CYCLES + 1);

  logic [CW-1:0] cnt;

  assign load = (state == ST_CONVERT) && (cnt == CW'(CONV_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_POWERUP;
      cnt   <= '0;
    end else begin
      case (state)
        ST_POWERUP: begin
          if (por_done) begin
            state <= ST_CONVERT;
            cnt   <= '0;
          end
        end
        ST_CONVERT: begin
          if (load) state <= ST_SLEEP;
          else      cnt   <= cnt + 1'b1;
        end
        ST_SLEEP: begin
          if (frame_done) begin
            state <= ST_CONVERT;
            cnt   <= '0;
          end
        end
        default: state <= ST_POWERUP;
      endcase
    end
  end
endmodule

// File: rtl/sck_source.sv
module sck_source #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic abort,
  input  logic frame_done,
  output logic sck_out,
  output logic sck_oe,
  output logic int_rise,
  output logic int_fall
);
  localparam int DW = $clog2(HALF_DIV + 1);

  logic [DW-1:0] div_cnt;
  logic          active;
  logic          tail;
  logic          sck_r;
  logic          tick;

  assign tick     = active && (div_cnt == DW'(HALF_DIV - 1));
  assign int_rise = tick && !sck_r && !tail;
  assign int_fall = tick && sck_r;
  assign sck_out  = sck_r;
  assign sck_oe   = active;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      tail    <= 1'b0;
      div_cnt <= '0;
      sck_r   <= 1'b0;
    end else if (start) begin
      active  <= 1'b1;
      tail    <= 1'b0;
      div_cnt <= '0;
      sck_r   <= 1'b0;
    end else if (active) begin
      if (abort) begin
        active <= 1'b0;
        sck_r  <= 1'b0;
      end else begin
        div_cnt <= tick ? '0 : div_cnt + 1'b1;
        if (tick) begin
          if (tail) begin
            active <= 1'b0;
            sck_r  <= 1'b0;
          end else begin
            sck_r <= ~sck_r;
          end
        end
        if (frame_done) tail <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int RES_W = 22,
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [RES_W-1:0] result_in,
  input  logic             shift_en,
  input  logic             in_conv,
  input  logic             rise_evt,
  input  logic             fall_evt,
  input  logic             sdi,
  output logic             sdo,
  output logic             frame_done,
  output logic [CFG_W-1:0] cfg_word
);
  localparam int FRAME_W = RES_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   fall_cnt;
  logic [CNT_W-1:0]   rise_cnt;
  logic [CFG_W-1:0]   in_sr;
  logic               header_ok;

  assign frame_done = shift_en && fall_evt && (fall_cnt == CNT_W'(FRAME_W - 1));
  assign header_ok  = (in_sr[CFG_W-1] == 1'b1) && (in_sr[CFG_W-2] == 1'b0);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      fall_cnt <= '0;
      rise_cnt <= '0;
      in_sr    <= '0;
      cfg_word <= '0;
    end else if (load) begin
      shreg    <= {2'b00, result_in};
      fall_cnt <= '0;
      rise_cnt <= '0;
      in_sr    <= '0;
    end else if (shift_en) begin
      if (rise_evt && (rise_cnt < CNT_W'(FRAME_W))) begin
        rise_cnt <= rise_cnt + 1'b1;
        if (rise_cnt < CNT_W'(CFG_W)) in_sr <= {in_sr[CFG_W-2:0], sdi};
      end
      if (fall_evt) begin
        shreg    <= {shreg[FRAME_W-2:0], 1'b0};
        fall_cnt <= fall_cnt + 1'b1;
        if (frame_done && header_ok) cfg_word <= in_sr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                       sdo <= 1'b1;
    else if (load)                 sdo <= 1'b0;
    else if (frame_done)           sdo <= 1'b1;
    else if (in_conv)              sdo <= 1'b1;
    else if (shift_en && fall_evt) sdo <= shreg[FRAME_W-2];
  end
endmodule

// File: rtl/adc_port_responder.sv
module adc_port_responder import port_resp_pkg::*; #(
  parameter int POR_CYCLES  = 4096,
  parameter int CONV_CYCLES = 8192,
  parameter int HALF_DIV    = 4,
  parameter int RES_W       = 22,
  parameter int CFG_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sck_pin,
  output logic             sck_out,
  output logic             sck_oe,
  input  logic             cs_n,
  input  logic             sdi,
  output logic             sdo,
  output logic             sdo_oe,
  input  logic [RES_W-1:0] result_in,
  output logic [CFG_W-1:0] cfg_word,
  output logic             mode_ext
);
  seq_state_t state;
  logic por_done, load, frame_done, converting;
  logic int_rise, int_fall, ext_rise, ext_fall;
  logic sck_q, start_burst, shift_en;

  assign converting  = (state == ST_CONVERT);
  assign shift_en    = (state == ST_SLEEP) && !cs_n;
  assign start_burst = !mode_ext && shift_en && !sck_oe;
  assign ext_rise    = mode_ext && !sck_q && sck_pin;
  assign ext_fall    = mode_ext && sck_q && !sck_pin;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q  <= 1'b1;
      sdo_oe <= 1'b0;
    end else begin
      sck_q  <= sck_pin;
      sdo_oe <= ~cs_n;
    end
  end

  por_mode_ctrl #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk(clk), .rst(rst), .sck_pin(sck_pin), .cs_n(cs_n),
    .sck_driving(sck_oe), .por_done(por_done), .mode_ext(mode_ext)
  );

  conv_sequencer #(.CONV_CYCLES(CONV_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .por_done(por_done), .frame_done(frame_done),
    .state(state), .load(load)
  );

  sck_source #(.HALF_DIV(HALF_DIV)) u_sck (
    .clk(clk), .rst(rst), .start(start_burst), .abort(cs_n),
    .frame_done(frame_done), .sck_out(sck_out), .sck_oe(sck_oe),
    .int_rise(int_rise), .int_fall(int_fall)
  );

  frame_shifter #(.RES_W(RES_W), .CFG_W(CFG_W)) u_shift (
    .clk(clk), .rst(rst), .load(load), .result_in(result_in),
    .shift_en(shift_en), .in_conv(state != ST_SLEEP),
    .rise_evt(ext_rise | int_rise), .fall_evt(ext_fall | int_fall),
    .sdi(sdi), .sdo(sdo), .frame_done(frame_done), .cfg_word(cfg_word)
  );
endmodule

// File: rtl/port_responder_chk.sv
module port_responder_chk #(
  parameter int CFG_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_n,
  input logic             sdo,
  input logic             sdo_oe,
  input logic             sck_oe,
  input logic             mode_ext,
  input logic             por_done,
  input logic             converting,
  input logic [CFG_W-1:0] cfg_word
);
  AST_POR_SDO_HIGH: assert property (@(posedge clk) disable iff (rst)
    !por_done |-> sdo); // R1
  AST_CONV_SDO_HIGH: assert property (@(posedge clk) disable iff (rst)
    (converting && $past(converting)) |-> sdo); // R2
  AST_CFG_HEADER: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_word) |-> (cfg_word[CFG_W-1:CFG_W-2] == 2'b10)); // R5
  AST_OE_ON: assert property (@(posedge clk) disable iff (rst)
    !cs_n |=> sdo_oe); // R8
  AST_OE_OFF: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !sdo_oe); // R8
  AST_EXT_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    mode_ext |-> !sck_oe); // R9
endmodule

bind adc_port_responder port_responder_chk #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sdo(sdo), .sdo_oe(sdo_oe),
  .sck_oe(sck_oe), .mode_ext(mode_ext), .por_done(por_done),
  .converting(converting), .cfg_word(cfg_word)
);

// File: tb/sim_adc_port_responder.sv
module sim_adc_port_responder;
  localparam int CLK_PERIOD = 10;
  localparam int POR  = 20;
  localparam int CONV = 50;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_sck = 1'b1;
  logic cs_n = 1'b0;
  logic sdi = 1'b0;
  logic [21:0] result_in = '0;
  logic sck_out, sck_oe, sdo, sdo_oe, mode_ext;
  logic [15:0] cfg_word;
  wire sck_line = sck_oe ? sck_out : host_sck;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [21:0] cur_res;
  logic [15:0] cfg_exp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_port_responder #(.POR_CYCLES(POR), .CONV_CYCLES(CONV), .HALF_DIV(HALF),
                       .RES_W(22), .CFG_W(16)) u0 (
    .clk(clk), .rst(rst), .sck_pin(sck_line), .sck_out(sck_out), .sck_oe(sck_oe),
    .cs_n(cs_n), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .result_in(result_in),
    .cfg_word(cfg_word), .mode_ext(mode_ext)
  );

  function automatic logic [23:0] frame_of(logic [21:0] r);
    return {2'b00, r};
  endfunction

  function automatic logic [15:0] next_cfg(logic [15:0] old, logic [23:0] w);
    return (w[23:22] == 2'b10) ? w[23:8] : old;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_eoc(output int cyc);
    cyc = 0;
    while (sdo !== 1'b0 && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  // host-clocked frame: sdi bit k shown before rise k, sdo checked before rise k
  task automatic ext_shift(input logic [21:0] r, input logic [23:0] w);
    logic [23:0] f;
    f = frame_of(r);
    for (int k = 0; k < 24; k++) begin
      sdi = w[23-k];
      @(negedge clk);
      chk(sdo === f[23-k], "R3 frame bit", sdo, f[23-k]);
      host_sck = 1'b1;
      repeat (2) @(negedge clk);
      host_sck = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic do_frame(input logic [23:0] w, input logic [21:0] nxt, input bit toggle);
    int c;
    int extra;
    ext_shift(cur_res, w);
    chk(sdo === 1'b1, "R4 sdo high after 24th fall", sdo, 1);
    cfg_exp = next_cfg(cfg_exp, w);
    chk(cfg_word === cfg_exp, "R5/R6 cfg word", cfg_word, cfg_exp);
    result_in = nxt;
    cur_res = nxt;
    c = 2;
    if (toggle) begin
      // R7: host edges during conversion must not move the frame
      for (int i = 0; i < 12; i++) begin
        host_sck = i[1];
        @(negedge clk);
        c++;
      end
      host_sck = 1'b0;
    end
    wait_eoc(extra);
    c += extra;
    chk(c >= CONV && c <= CONV + 2, "R2 conversion length", c, CONV + 1);
  endtask

  task automatic int_frame(input logic [21:0] r, input logic [23:0] w);
    logic [23:0] f;
    int nf, nr, cyc, last, guard;
    bit per_ok;
    logic prev, cur;
    f = frame_of(r);
    nf = 0; nr = 0; cyc = 0; last = -1; guard = 0; per_ok = 1'b1;
    sdi = w[23];
    while (sck_oe !== 1'b1 && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    chk(sck_oe === 1'b1, "R9 block drives clock", sck_oe, 1);
    prev = sck_line;
    while (nf < 24 && guard < 6000) begin
      @(negedge clk);
      guard++;
      cyc++;
      cur = sck_line;
      if (!prev && cur) begin
        chk(sdo === f[23-nr], "R3 self-clocked frame bit", sdo, f[23-nr]);
        nr++;
      end
      if (prev && !cur) begin
        nf++;
        if (last >= 0 && (cyc - last) != 2*HALF) per_ok = 1'b0;
        last = cyc;
        if (nf < 24) sdi = w[23-nf];
      end
      prev = cur;
    end
    chk(nf == 24, "R9 falling edge count", nf, 24);
    chk(per_ok, "R9 clock period", per_ok, 1);
    repeat (3) @(negedge clk);
    chk(sdo === 1'b1, "R4 new conversion after self-clocked frame", sdo, 1);
    chk(sck_oe === 1'b0, "R9 clock released", sck_oe, 0);
    cfg_exp = next_cfg(cfg_exp, w);
    chk(cfg_word === cfg_exp, "R5 cfg from self-clocked frame", cfg_word, cfg_exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int t;
    logic [31:0] seed;
    seed = $urandom(32'd24601);
    cur_res = 22'h2A5F3C;
    result_in = cur_res;
    repeat (3) @(negedge clk);
    // R11 reset values
    chk(mode_ext === 1'b0, "R11 mode in reset", mode_ext, 0);
    chk(cfg_word === 16'h0, "R11 cfg in reset", cfg_word, 0);
    chk(sdo === 1'b1, "R11 sdo in reset", sdo, 1);
    chk(sck_oe === 1'b0, "R11 sck_oe in reset", sck_oe, 0);
    host_sck = 1'b0;
    rst = 1'b0;
    t = 0;
    while (sdo !== 1'b0 && t < 3000) begin
      @(negedge clk);
      t++;
      if (t == POR - 2) begin
        chk(mode_ext === 1'b0, "R1 mode before interval end", mode_ext, 0);
        chk(sdo === 1'b1, "R1 sdo during power-up", sdo, 1);
      end
      if (t == POR + 3) chk(mode_ext === 1'b1, "R1 low clock selects host mode", mode_ext, 1);
      if (t == POR + CONV - 2) chk(sdo === 1'b1, "R2 busy flag", sdo, 1);
    end
    chk(t >= POR + CONV && t <= POR + CONV + 2, "R2 first completion time", t, POR + CONV + 1);
    chk(sdo_oe === 1'b1, "R8 output enabled with cs low", sdo_oe, 1);

    do_frame(24'hA5C3FF, 22'h155AA1, 1'b0);   // R5 header 10 accepted
    do_frame(24'hE12300, 22'h3FFFFF, 1'b0);   // R6 header 11 rejected
    do_frame(24'h7FFF00, 22'h000001, 1'b1);   // R6 header 01, R7 edges in conversion
    do_frame(24'h800000, 22'h200000, 1'b0);   // R5 minimal valid word

    // R7/R8: edges with cs high are ignored
    cs_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      host_sck = ~host_sck;
      @(negedge clk);
      @(negedge clk);
      if (i == 0) chk(sdo_oe === 1'b0, "R8 output disabled with cs high", sdo_oe, 0);
    end
    host_sck = 1'b0;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(mode_ext === 1'b1, "R10 low clock at cs fall keeps host mode", mode_ext, 1);
    chk(sdo === 1'b0, "R7 frame not advanced while deselected", sdo, 0);

    for (int n = 0; n < 6; n++) begin
      logic [23:0] w;
      w = $urandom();
      if ($urandom() % 2 == 0) w[23:22] = 2'b10;
      do_frame(w, 22'($urandom()), (n == 2));
    end

    // R10: high clock at cs fall selects self-clocked mode
    cs_n = 1'b1;
    host_sck = 1'b1;
    result_in = 22'h1C0F0E;
    repeat (2) @(negedge clk);
    cs_n = 1'b0;
    @(negedge clk);
    chk(mode_ext === 1'b0, "R10 re-latch to self-clocked", mode_ext, 0);
    int_frame(cur_res, 24'hB00B55);
    cs_n = 1'b1;
    repeat (5) @(negedge clk);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule